// File: doc/BRIEF.md
# UART Status Flag and Interrupt Controller

This block keeps the sticky status flags of a serial port, the interrupt enables, the send-break request and the two DMA request outputs. The transmit and receive datapaths are not part of it. They send one-cycle event pulses, and each pulse sets the matching flag. Software reaches the block through a small register bus with one access per cycle. Read data is combinational from the addressed register.

A flag is not cleared by writing a one to it. Each flag is cleared by a rule tied to the order of bus accesses. A read of the status register takes a snapshot of the flags that are set. A following data-register read clears the error and idle flags that were in that snapshot. A following data-register write clears the transmit-complete flag if it was in the snapshot. Any data access uses up the snapshot. A flag raised between the status read and the data access therefore stays pending. The receive-full and transmit-complete flags can also be cleared by writing a zero to their status bits. The transmit-empty flag is cleared only by a data write.

All enabled pending sources are combined into one interrupt line, which is registered by default. The DMA request for each direction is the related data flag gated by its own enable.

Top module: `uart_flag_ctrl`

Register offsets (defaults): status 0, data 1, config A 2, config B 3, config C 4. Status bits: 0 parity error, 1 framing error, 2 noise, 3 overrun, 4 idle, 5 receive full, 6 transmit complete, 7 transmit empty. Config A bit 0: parity interrupt enable. Config B: bit 0 transmit-empty enable, bit 1 transmit-complete enable, bit 2 receive enable, bit 3 idle enable, bit 4 send-break request. Config C: bit 0 error interrupt enable, bit 1 transmit DMA enable, bit 2 receive DMA enable. Event input bit n sets status bit n.

## Requirements
- R1: After reset the status register reads 0xC0, all three config registers read 0, and irq_o, dma_tx_req and dma_rx_req are low.
- R2: A pulse on ev_flags bit n sets status bit n at the next clock edge. The bit then stays set until its clear rule applies.
- R3: Status bits 0 to 4 are cleared by a data-register read only when a status read came before it, with no other data access in between. A data read without that earlier status read leaves them set.
- R4: The clear that completes a sequence affects only the flags that were set at the status read. A flag raised after the status read stays set.
- R5: Status bit 5 is cleared by any data-register read, and also by a status write with bit 5 at 0. A status write with bit 5 at 1 leaves it unchanged.
- R6: Status bit 6 is cleared by a status read followed by a data write, or by a status write with bit 6 at 0. A data write without an earlier status read leaves it set.
- R7: Status bit 7 is cleared only by a data-register write. Writing 0 to status bit 7 has no effect.
- R8: If an event pulse and a clear for the same flag fall in the same cycle, the flag stays set.
- R9: Config B bit 4 is set by software and cleared by a pulse on ev_break_stop. If the pulse and a write fall in the same cycle, the pulse wins.
- R10: irq_o is high one cycle after any of these holds: bit0 and parity enable; (bit1 or bit2) and error enable; bit3 and (receive enable or error enable); bit4 and idle enable; bit5 and receive enable; bit6 and transmit-complete enable; bit7 and transmit-empty enable.
- R11: dma_tx_req equals status bit 7 AND config C bit 1. dma_rx_req equals status bit 5 AND config C bit 2.
- R12: The config registers read back their defined bits and read 0 in undefined bits. The data register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ev_flags | input | 8 | Event pulses, bit n sets status bit n |
| ev_break_stop | input | 1 | Stop bit of a break frame reached |
| irq_o | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with its default parameters: a 3-bit address and a registered interrupt. With these values every register is reachable and the interrupt is one cycle behind the flags. It sweeps all 64 settings of the six interrupt enables against each of the eight single-flag sources, and each expected interrupt level is worked out from the R10 equation. It also tries every pairing of the DMA enables with the two data flags. Ordered access sequences test the snapshot rule, the write-zero clears and a set and a clear landing in the same cycle.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
   localparam int BYTE_W = 8;

   localparam int F_PAR  = 0;
   localparam int F_FRM  = 1;
   localparam int F_NSE  = 2;
   localparam int F_OVR  = 3;
   localparam int F_IDL  = 4;
   localparam int F_RXF  = 5;
   localparam int F_TXC  = 6;
   localparam int F_TXE  = 7;

   localparam logic [BYTE_W-1:0] STAT_RST = 8'hC0;

   typedef struct packed {
      logic par_ie;
      logic txe_ie;
      logic txc_ie;
      logic rx_ie;
      logic idl_ie;
      logic brk;
      logic err_ie;
      logic dtx_en;
      logic drx_en;
   } cfg_t;
endpackage

// File: rtl/uart_flag_cfg.sv
module uart_flag_cfg
   import uart_flag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_a,
   input  logic       wr_b,
   input  logic       wr_c,
   input  logic [4:0] wbits,
   input  logic       brk_done,
   output cfg_t       cfg_o,
   output logic [BYTE_W-1:0] rd_a,
   output logic [BYTE_W-1:0] rd_b,
   output logic [BYTE_W-1:0] rd_c
);
   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (wr_a) cfg_q.par_ie <= wbits[0];
         if (wr_b) begin
            cfg_q.txe_ie <= wbits[0];
            cfg_q.txc_ie <= wbits[1];
            cfg_q.rx_ie  <= wbits[2];
            cfg_q.idl_ie <= wbits[3];
         end
         // break request: hardware completion beats a software write
         if (brk_done)  cfg_q.brk <= 1'b0;
         else if (wr_b) cfg_q.brk <= wbits[4];
         if (wr_c) begin
            cfg_q.err_ie <= wbits[0];
            cfg_q.dtx_en <= wbits[1];
            cfg_q.drx_en <= wbits[2];
         end
      end
   end

   assign cfg_o = cfg_q;
   assign rd_a  = {7'b0, cfg_q.par_ie};
   assign rd_b  = {3'b0, cfg_q.brk, cfg_q.idl_ie, cfg_q.rx_ie, cfg_q.txc_ie, cfg_q.txe_ie};
   assign rd_c  = {5'b0, cfg_q.drx_en, cfg_q.dtx_en, cfg_q.err_ie};
endmodule

// File: rtl/uart_flag_status.sv
module uart_flag_status
   import uart_flag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_rd,
   input  logic              stat_wr,
   input  logic              data_rd,
   input  logic              data_wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [BYTE_W-1:0] ev,
   output logic [BYTE_W-1:0] stat_o
);
   localparam int ERR_N = F_IDL + 1;

   // snapshot of clear-by-sequence flags: error/idle group plus transmit-complete
   logic [ERR_N:0]      arm_q;
   logic [BYTE_W-1:0]   clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               arm_q <= '0;
      else if (stat_rd)         arm_q <= {stat_o[F_TXC], stat_o[ERR_N-1:0]};
      else if (data_rd | data_wr) arm_q <= '0;
   end

   always_comb begin
      clr          = '0;
      clr[ERR_N-1:0] = {ERR_N{data_rd}} & arm_q[ERR_N-1:0];
      clr[F_RXF]   = data_rd | (stat_wr & ~wdata[F_RXF]);
      clr[F_TXC]   = (data_wr & arm_q[ERR_N]) | (stat_wr & ~wdata[F_TXC]);
      clr[F_TXE]   = data_wr;
   end

   for (genvar i = 0; i < BYTE_W; i++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= STAT_RST[i];
         else        flag_q <= ev[i] | (flag_q & ~clr[i]);
      end
      assign stat_o[i] = flag_q;
   end
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
   import uart_flag_pkg::*;
#(
   parameter int IRQ_REG = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] stat,
   input  logic              par_ie,
   input  logic              txe_ie,
   input  logic              txc_ie,
   input  logic              rx_ie,
   input  logic              idl_ie,
   input  logic              err_ie,
   input  logic              dtx_en,
   input  logic              drx_en,
   output logic              irq_o,
   output logic              dma_tx_o,
   output logic              dma_rx_o
);
   logic irq_raw;

   always_comb begin
      irq_raw = (stat[F_PAR] & par_ie)
              | ((stat[F_FRM] | stat[F_NSE]) & err_ie)
              | (stat[F_OVR] & (rx_ie | err_ie))
              | (stat[F_IDL] & idl_ie)
              | (stat[F_RXF] & rx_ie)
              | (stat[F_TXC] & txc_ie)
              | (stat[F_TXE] & txe_ie);
   end

   if (IRQ_REG != 0) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
   end

   assign dma_tx_o = stat[F_TXE] & dtx_en;
   assign dma_rx_o = stat[F_RXF] & drx_en;
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
   import uart_flag_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int STAT_OFS = 0,
   parameter int DATA_OFS = 1,
   parameter int CFGA_OFS = 2,
   parameter int CFGB_OFS = 3,
   parameter int CFGC_OFS = 4,
   parameter int IRQ_REG  = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        ev_flags,
   input  logic              ev_break_stop,
   output logic              irq_o,
   output logic              dma_tx_req,
   output logic              dma_rx_req
);
   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] A_CFGA = ADDR_W'(CFGA_OFS);
   localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'(CFGB_OFS);
   localparam logic [ADDR_W-1:0] A_CFGC = ADDR_W'(CFGC_OFS);

   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_aw
      $error("uart_flag_ctrl: ADDR_W out of range");
   end
   if (STAT_OFS >= ADDR_SPAN || DATA_OFS >= ADDR_SPAN || CFGA_OFS >= ADDR_SPAN ||
       CFGB_OFS >= ADDR_SPAN || CFGC_OFS >= ADDR_SPAN) begin : g_bad_ofs
      $error("uart_flag_ctrl: register offset outside address span");
   end
   if (STAT_OFS == DATA_OFS || STAT_OFS == CFGA_OFS || STAT_OFS == CFGB_OFS ||
       STAT_OFS == CFGC_OFS || DATA_OFS == CFGA_OFS || DATA_OFS == CFGB_OFS ||
       DATA_OFS == CFGC_OFS || CFGA_OFS == CFGB_OFS || CFGA_OFS == CFGC_OFS ||
       CFGB_OFS == CFGC_OFS) begin : g_bad_dup
      $error("uart_flag_ctrl: register offsets overlap");
   end
   if (IRQ_REG != 0 && IRQ_REG != 1) begin : g_bad_irq
      $error("uart_flag_ctrl: IRQ_REG must be 0 or 1");
   end

   logic rd_go, wr_go;
   logic stat_rd, stat_wr, data_rd, data_wr;
   logic wr_a, wr_b, wr_c;
   logic [BYTE_W-1:0] stat_q, rd_a, rd_b, rd_c;
   cfg_t cfg_q;

   assign rd_go   = bus_sel & bus_rd;
   assign wr_go   = bus_sel & bus_wr;
   assign stat_rd = rd_go & (bus_addr == A_STAT);
   assign stat_wr = wr_go & (bus_addr == A_STAT);
   assign data_rd = rd_go & (bus_addr == A_DATA);
   assign data_wr = wr_go & (bus_addr == A_DATA);
   assign wr_a    = wr_go & (bus_addr == A_CFGA);
   assign wr_b    = wr_go & (bus_addr == A_CFGB);
   assign wr_c    = wr_go & (bus_addr == A_CFGC);

   uart_flag_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_rd (stat_rd),
      .stat_wr (stat_wr),
      .data_rd (data_rd),
      .data_wr (data_wr),
      .wdata   (bus_wdata),
      .ev      (ev_flags),
      .stat_o  (stat_q)
   );

   uart_flag_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_a     (wr_a),
      .wr_b     (wr_b),
      .wr_c     (wr_c),
      .wbits    (bus_wdata[4:0]),
      .brk_done (ev_break_stop),
      .cfg_o    (cfg_q),
      .rd_a     (rd_a),
      .rd_b     (rd_b),
      .rd_c     (rd_c)
   );

   uart_flag_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat     (stat_q),
      .par_ie   (cfg_q.par_ie),
      .txe_ie   (cfg_q.txe_ie),
      .txc_ie   (cfg_q.txc_ie),
      .rx_ie    (cfg_q.rx_ie),
      .idl_ie   (cfg_q.idl_ie),
      .err_ie   (cfg_q.err_ie),
      .dtx_en   (cfg_q.dtx_en),
      .drx_en   (cfg_q.drx_en),
      .irq_o    (irq_o),
      .dma_tx_o (dma_tx_req),
      .dma_rx_o (dma_rx_req)
   );

   always_comb begin
      if (bus_addr == A_STAT)      bus_rdata = stat_q;
      else if (bus_addr == A_CFGA) bus_rdata = rd_a;
      else if (bus_addr == A_CFGB) bus_rdata = rd_b;
      else if (bus_addr == A_CFGC) bus_rdata = rd_c;
      else                         bus_rdata = '0;
   end
endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk #(
   parameter int IRQ_REG = 1
)(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] stat,
   input logic [7:0] ev_flags,
   input logic       data_rd,
   input logic       data_wr,
   input logic       brk_stop,
   input logic       brk_bit,
   input logic       dtx_en,
   input logic       drx_en,
   input logic       dma_tx_req,
   input logic       dma_rx_req,
   input logic       irq_o
);
   // R2: every pulsed event bit is set one cycle later
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_flags) |=> ((stat & $past(ev_flags)) == $past(ev_flags)));

   // R3: without a data read the error/idle group never drops
   a_r3_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_rd && (|stat[4:0])) |=> ((stat[4:0] & $past(stat[4:0])) == $past(stat[4:0])));

   // R5: a data read empties receive-full unless refilled in the same cycle
   a_r5_rxf_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !ev_flags[5]) |=> !stat[5]);

   // R7: transmit-empty survives anything except a data write
   a_r7_txe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[7] && !data_wr) |=> stat[7]);

   // R9: break completion always drops the request
   a_r9_break_clear: assert property (@(posedge clk) disable iff (!rst_n)
      brk_stop |=> !brk_bit);

   // R11: DMA requests follow flag and enable
   a_r11_dma_tx: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tx_req == (stat[7] && dtx_en));
   a_r11_dma_rx: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rx_req == (stat[5] && drx_en));

   // R10: no pending flag means no interrupt
   if (IRQ_REG != 0) begin : g_q
      a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (stat == 8'h00) |=> !irq_o);
   end else begin : g_c
      a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (stat == 8'h00) |-> !irq_o);
   end
endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk #(.IRQ_REG(IRQ_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stat       (stat_q),
   .ev_flags   (ev_flags),
   .data_rd    (data_rd),
   .data_wr    (data_wr),
   .brk_stop   (ev_break_stop),
   .brk_bit    (cfg_q.brk),
   .dtx_en     (cfg_q.dtx_en),
   .drx_en     (cfg_q.drx_en),
   .dma_tx_req (dma_tx_req),
   .dma_rx_req (dma_rx_req),
   .irq_o      (irq_o)
);

// File: tb/uart_flag_ctrl_tb_top.sv
module uart_flag_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] ev_flags = '0;
   logic       ev_break_stop = 1'b0;
   logic       irq_o, dma_tx_req, dma_rx_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [2:0] A_ST = 3'd0, A_DT = 3'd1, A_CA = 3'd2, A_CB = 3'd3, A_CC = 3'd4;

   always #5 clk = ~clk;

   uart_flag_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_flags(ev_flags), .ev_break_stop(ev_break_stop), .irq_o(irq_o),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // one cycle: starts and ends at a falling edge
   task automatic step(input logic sel, input logic wr, input logic [2:0] a,
                       input logic [7:0] d, input logic [7:0] ev, input logic brk,
                       output logic [7:0] rd);
      bus_sel = sel; bus_wr = wr; bus_rd = sel & ~wr; bus_addr = a; bus_wdata = d;
      ev_flags = ev; ev_break_stop = brk;
      #1 rd = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; ev_flags = '0; ev_break_stop = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      step(1'b1, 1'b0, a, 8'h00, 8'h00, 1'b0, v);
   endtask
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      logic [7:0] x;
      step(1'b1, 1'b1, a, d, 8'h00, 1'b0, x);
   endtask
   task automatic pulse(input logic [7:0] ev);
      logic [7:0] x;
      step(1'b0, 1'b0, 3'd0, 8'h00, ev, 1'b0, x);
   endtask
   task automatic clear_all();
      logic [7:0] x;
      rd(A_ST, x); rd(A_DT, x); rd(A_ST, x); wr(A_DT, 8'h00);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", {7'b0, irq_o}, 8'h00);
      check("R1 dma", {6'b0, dma_tx_req, dma_rx_req}, 8'h00);
      rd(A_ST, v); check("R1 status", v, 8'hC0);
      rd(A_CA, v); check("R1 cfgA", v, 8'h00);
      rd(A_CB, v); check("R1 cfgB", v, 8'h00);
      rd(A_CC, v); check("R1 cfgC", v, 8'h00);

      // R12 readback masks
      wr(A_CA, 8'hFF); rd(A_CA, v); check("R12 cfgA", v, 8'h01);
      wr(A_CC, 8'hFF); rd(A_CC, v); check("R12 cfgC", v, 8'h07);
      wr(A_CB, 8'h0F); rd(A_CB, v); check("R12 cfgB", v, 8'h0F);
      rd(A_DT, v); check("R12 data reads zero", v, 8'h00);
      wr(A_CA, 8'h00); wr(A_CB, 8'h00); wr(A_CC, 8'h00);

      // R9 break request
      wr(A_CB, 8'h10); rd(A_CB, v); check("R9 break set", v, 8'h10);
      step(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b1, v);
      rd(A_CB, v); check("R9 break cleared", v, 8'h00);
      step(1'b1, 1'b1, A_CB, 8'h10, 8'h00, 1'b1, v);
      rd(A_CB, v); check("R9 stop beats write", v, 8'h00);

      // R2 / R3 error and idle group
      for (int i = 0; i < 5; i++) begin
         clear_all();
         pulse(8'(1 << i));
         rd(A_DT, v);
         rd(A_ST, v); check("R2 set / R3 unarmed read keeps", v, 8'(1 << i));
         rd(A_DT, v);
         rd(A_ST, v); check("R3 sequence clears", v, 8'h00);
      end

      // R4 late event survives
      clear_all();
      pulse(8'h01); rd(A_ST, v); pulse(8'h02); rd(A_DT, v);
      rd(A_ST, v); check("R4 only snapshot cleared", v, 8'h02);

      // R5 receive-full
      clear_all();
      pulse(8'h20); rd(A_ST, v); check("R5 set", v, 8'h20);
      rd(A_DT, v); rd(A_ST, v); check("R5 data read clears", v, 8'h00);
      pulse(8'h20); wr(A_ST, 8'hFF); rd(A_ST, v); check("R5 write one keeps", v, 8'h20);
      wr(A_ST, 8'hDF); rd(A_ST, v); check("R5 write zero clears", v, 8'h00);

      // R6 transmit-complete
      clear_all();
      pulse(8'h40); wr(A_DT, 8'h00);
      rd(A_ST, v); check("R6 unarmed write keeps", v, 8'h40);
      wr(A_DT, 8'h00); rd(A_ST, v); check("R6 sequence clears", v, 8'h00);
      pulse(8'h40); wr(A_ST, 8'hBF); rd(A_ST, v); check("R6 write zero clears", v, 8'h00);

      // R7 transmit-empty
      clear_all();
      pulse(8'h80); wr(A_ST, 8'h00); rd(A_ST, v); check("R7 write zero ignored", v, 8'h80);
      wr(A_DT, 8'h00); rd(A_ST, v); check("R7 data write clears", v, 8'h00);

      // R8 set beats clear
      clear_all();
      pulse(8'h01); rd(A_ST, v);
      step(1'b1, 1'b0, A_DT, 8'h00, 8'h21, 1'b0, v);
      rd(A_ST, v); check("R8 set wins", v, 8'h21);

      // R10 sweep: enables x single source
      for (int en = 0; en < 64; en++) begin
         for (int s = 0; s < 8; s++) begin
            logic e;
            logic [7:0] cb;
            clear_all();
            cb = {4'b0, en[4], en[3], en[2], en[1]};
            wr(A_CA, {7'b0, en[0]}); wr(A_CB, cb); wr(A_CC, {7'b0, en[5]});
            case (s)
               0: e = en[0];
               1, 2: e = en[5];
               3: e = en[3] | en[5];
               4: e = en[4];
               5: e = en[3];
               6: e = en[2];
               default: e = en[1];
            endcase
            pulse(8'(1 << s));
            check("R10 irq lags flag", {7'b0, irq_o}, 8'h00);
            pulse(8'h00);
            check($sformatf("R10 irq en=%0d src=%0d", en, s), {7'b0, irq_o}, {7'b0, e});
         end
      end
      wr(A_CA, 8'h00); wr(A_CB, 8'h00);

      // R11 DMA sweep
      for (int en = 0; en < 4; en++) begin
         for (int f = 0; f < 4; f++) begin
            clear_all();
            wr(A_CC, 8'(en << 1));
            pulse({f[0], 1'b0, f[1], 5'b0});
            check($sformatf("R11 dma en=%0d f=%0d", en, f),
                  {6'b0, dma_tx_req, dma_rx_req},
                  {6'b0, en[0] & f[0], en[1] & f[1]});
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule